// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block holds the operating clock mode of a small microcontroller core. There are three running modes: full-speed active, medium-speed active and subactive (low-speed clock). There are also two halted modes: sleep, reached from the active modes, and watch, reached from subactive or used as the passage into and out of it. When the CPU issues a sleep request, the block reads a set of control bits and decides one of two outcomes. The core may halt until a wake-up interrupt arrives. Or it may pass through sleep or watch and land in a different running mode without losing program execution. The second outcome is a direct transfer.

A direct transfer needs the direct-transfer enable bit set, the direct-transfer interrupt enabled and the CPU interrupt mask clear. When it reaches its target mode, the block raises a one-cycle direct-transfer interrupt request. The move from subactive back to full speed waits for the fast clock to settle. That wait is counted in low-speed clock ticks, and a 3-bit select field chooses its length. If the bits describe a direct path but the interrupt is disabled or masked, the request becomes a true halt in the intermediate mode. Under a mask that halt cannot be left by any interrupt. Only control and status pins are present, and no data stream passes through the block, so it has no valid/ready interface.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode is full-speed active, clk_sel is 2'b00 and dt_irq is 0.
- R2: mode_oh is always one-hot with bit 0 = full-speed, 1 = medium-speed, 2 = subactive, 3 = sleep, 4 = watch. clk_sel is 2'b00 for full-speed, 2'b01 for medium-speed, 2'b10 for subactive and 2'b11 for sleep or watch.
- R3: In full-speed, a sleep request with stby_sel=0, lowspd_sel=0, medspd_sel=1 and dt_en=1 (interrupt enabled, unmasked) enters sleep for exactly one cycle and then medium-speed.
- R4: In medium-speed, a sleep request with stby_sel=0, lowspd_sel=0, medspd_sel=0 and dt_en=1 (interrupt enabled, unmasked) enters sleep for one cycle and then full-speed.
- R5: In full-speed or medium-speed, a sleep request with stby_sel=1, lowspd_sel=1, dt_en=1 and tmr_lowclk=1 enters watch for one cycle and then subactive. Subactive is only ever entered from watch.
- R6: In subactive, a sleep request with stby_sel=1, lowspd_sel=0, medspd_sel=0, dt_en=1 and tmr_lowclk=1 enters watch. The block moves to full-speed on the clock edge that samples the (8 << wait_sel)-th lowclk_tick after the edge that entered watch. wait_sel is captured at the request, so later changes to it have no effect.
- R7: dt_irq is high for exactly one cycle, in the first cycle of the target running mode of a direct transfer, and at no other time.
- R8: If a direct path matches but dt_irq_en=0, the block stays in the intermediate sleep or watch mode. An unmasked wake_irq returns it to the mode it left, with no dt_irq.
- R9: If a direct path matches while irq_mask=1, the block stays in the intermediate mode. wake_irq does not release it, even after irq_mask is cleared. Only reset does.
- R10: A sleep request matching no direct path enters sleep from full-speed or medium-speed, and watch from subactive. No settling wait applies there. wake_irq with irq_mask=0 returns the block to the mode it left, while wake_irq with irq_mask=1 is ignored.
- R11: sleep_req has no effect while the block is in sleep or watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| stby_sel | input | 1 | Standby-select control bit |
| lowspd_sel | input | 1 | Low-speed-select control bit |
| medspd_sel | input | 1 | Medium-speed-select control bit |
| dt_en | input | 1 | Direct-transfer enable bit |
| tmr_lowclk | input | 1 | Timer clock-source bit (1 = timer runs from the low-speed clock) |
| wait_sel | input | 3 | Settling-wait select, wait = 8 << wait_sel low-speed ticks |
| dt_irq_en | input | 1 | Direct-transfer interrupt enable |
| irq_mask | input | 1 | CPU interrupt mask (1 = masked) |
| wake_irq | input | 1 | Wake-up interrupt request |
| lowclk_tick | input | 1 | One-cycle enable per low-speed clock period |
| mode_oh | output | 5 | One-hot current mode |
| clk_sel | output | 2 | Clock-select code |
| dt_irq | output | 1 | One-cycle direct-transfer interrupt request |

## Verification
The hardest state to reach is the locked halt: a direct path chosen while interrupts are masked. The bench first puts the block in that halt. It then offers wake-up interrupts both under the mask and after the mask is cleared, and confirms that only reset ends the halt. The settling wait is the other awkward case. The bench counts cycles spent in watch for several select codes. It also counts them with lowclk_tick held high on alternate cycles only, and changes wait_sel during the wait. These runs show that the count follows ticks rather than cycles and uses the captured select value.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int NUM_MODES = 5;

  // Enum value doubles as the bit position in the one-hot mode output.
  typedef enum logic [2:0] {
    MODE_FULL  = 3'd0,
    MODE_MED   = 3'd1,
    MODE_SUB   = 3'd2,
    MODE_SLEEP = 3'd3,
    MODE_WATCH = 3'd4
  } lpm_mode_e;

  localparam logic [1:0] CLK_FULL = 2'b00;
  localparam logic [1:0] CLK_MED  = 2'b01;
  localparam logic [1:0] CLK_LOW  = 2'b10;
  localparam logic [1:0] CLK_OFF  = 2'b11;

  typedef struct packed {
    logic stby;
    logic lowspd;
    logic medspd;
    logic dt_en;
    logic tmr_low;
  } lpm_cfg_t;

  typedef struct packed {
    logic      hit;     // a direct path matches the control bits
    lpm_mode_e halt;    // intermediate or parking mode
    lpm_mode_e target;  // running mode at the end of the path
    logic      settle;  // path needs the settling wait
  } lpm_path_t;

  function automatic logic is_running(input lpm_mode_e m);
    return (m == MODE_FULL) || (m == MODE_MED) || (m == MODE_SUB);
  endfunction

endpackage

// File: rtl/lpm_path_decode.sv
module lpm_path_decode
  import lpm_pkg::*;
(
  input  lpm_mode_e cur,
  input  lpm_cfg_t  cfg,
  output lpm_path_t path
);

  logic in_full, in_med, in_sub, in_active;
  logic p_full_med, p_med_full, p_act_sub, p_sub_full;

  always_comb begin
    in_full   = (cur == MODE_FULL);
    in_med    = (cur == MODE_MED);
    in_sub    = (cur == MODE_SUB);
    in_active = in_full | in_med;

    p_full_med = in_full & ~cfg.stby & ~cfg.lowspd &  cfg.medspd & cfg.dt_en;
    p_med_full = in_med  & ~cfg.stby & ~cfg.lowspd & ~cfg.medspd & cfg.dt_en;
    p_act_sub  = in_active & cfg.stby & cfg.lowspd & cfg.dt_en & cfg.tmr_low;
    p_sub_full = in_sub & cfg.stby & ~cfg.lowspd & ~cfg.medspd & cfg.dt_en & cfg.tmr_low;

    path.hit    = p_full_med | p_med_full | p_act_sub | p_sub_full;
    path.settle = p_sub_full;

    if (p_act_sub) begin
      path.target = MODE_SUB;
    end else if (p_full_med) begin
      path.target = MODE_MED;
    end else begin
      path.target = MODE_FULL;
    end

    if (p_act_sub | p_sub_full) begin
      path.halt = MODE_WATCH;
    end else if (path.hit) begin
      path.halt = MODE_SLEEP;
    end else begin
      path.halt = in_sub ? MODE_WATCH : MODE_SLEEP;
    end
  end

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int BASE_LOG2 = 3,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  output logic             done
);

  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

  logic             running_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_q;

  assign done = running_q & tick & (cnt_q == limit_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      limit_q   <= '0;
    end else if (start) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
      limit_q   <= CNT_W'(1) << (BASE_LOG2 + int'(sel));
    end else if (done) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (running_q && tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/lpm_mode_encode.sv
module lpm_mode_encode
  import lpm_pkg::*;
(
  input  lpm_mode_e             mode,
  output logic [NUM_MODES-1:0]  mode_oh,
  output logic [1:0]            clk_sel
);

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_oh
    assign mode_oh[i] = (mode == lpm_mode_e'(i));
  end

  always_comb begin
    unique case (mode)
      MODE_FULL: clk_sel = CLK_FULL;
      MODE_MED:  clk_sel = CLK_MED;
      MODE_SUB:  clk_sel = CLK_LOW;
      default:   clk_sel = CLK_OFF;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SETTLE_BASE_LOG2 = 3,
  parameter int WAIT_SEL_W       = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sleep_req,
  input  logic                  stby_sel,
  input  logic                  lowspd_sel,
  input  logic                  medspd_sel,
  input  logic                  dt_en,
  input  logic                  tmr_lowclk,
  input  logic [WAIT_SEL_W-1:0] wait_sel,
  input  logic                  dt_irq_en,
  input  logic                  irq_mask,
  input  logic                  wake_irq,
  input  logic                  lowclk_tick,
  output logic [4:0]            mode_oh,
  output logic [1:0]            clk_sel,
  output logic                  dt_irq
);

  lpm_mode_e mode_q, home_q, tgt_q;
  logic      transit_q, settle_q, locked_q, dt_irq_q;
  lpm_cfg_t  cfg;
  lpm_path_t path;
  logic      run_now, accept, direct_ok, timer_start, settle_done;
  logic      arrive, wake_ok;

  assign cfg = '{stby: stby_sel, lowspd: lowspd_sel, medspd: medspd_sel,
                 dt_en: dt_en, tmr_low: tmr_lowclk};

  lpm_path_decode u_decode (
    .cur  (mode_q),
    .cfg  (cfg),
    .path (path)
  );

  always_comb begin
    run_now     = is_running(mode_q);
    accept      = run_now & sleep_req;
    direct_ok   = path.hit & dt_irq_en & ~irq_mask;
    timer_start = accept & direct_ok & path.settle;
    arrive      = ~run_now & transit_q & (~settle_q | settle_done);
    wake_ok     = ~run_now & ~transit_q & ~locked_q & wake_irq & ~irq_mask;
  end

  lpm_settle_timer #(
    .BASE_LOG2 (SETTLE_BASE_LOG2),
    .SEL_W     (WAIT_SEL_W)
  ) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (timer_start),
    .sel   (wait_sel),
    .tick  (lowclk_tick),
    .done  (settle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_FULL;
      home_q    <= MODE_FULL;
      tgt_q     <= MODE_FULL;
      transit_q <= 1'b0;
      settle_q  <= 1'b0;
      locked_q  <= 1'b0;
      dt_irq_q  <= 1'b0;
    end else begin
      dt_irq_q <= 1'b0;
      if (accept) begin
        mode_q    <= path.halt;
        home_q    <= mode_q;
        tgt_q     <= path.target;
        transit_q <= direct_ok;
        settle_q  <= direct_ok & path.settle;
        locked_q  <= path.hit & irq_mask;
      end else if (arrive) begin
        mode_q    <= tgt_q;
        transit_q <= 1'b0;
        settle_q  <= 1'b0;
        dt_irq_q  <= 1'b1;
      end else if (wake_ok) begin
        mode_q <= home_q;
      end
    end
  end

  lpm_mode_encode u_encode (
    .mode    (mode_q),
    .mode_oh (mode_oh),
    .clk_sel (clk_sel)
  );

  assign dt_irq = dt_irq_q;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic [4:0] mode_oh,
  input logic [1:0] clk_sel,
  input logic       dt_irq
);

  localparam int B_FULL  = 0;
  localparam int B_MED   = 1;
  localparam int B_SUB   = 2;
  localparam int B_SLEEP = 3;
  localparam int B_WATCH = 4;

  logic running, halted;
  assign running = mode_oh[B_FULL] | mode_oh[B_MED] | mode_oh[B_SUB];
  assign halted  = mode_oh[B_SLEEP] | mode_oh[B_WATCH];

  assert_mode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);

  assert_halt_clkoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> clk_sel == 2'b11);

  assert_sub_from_watch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[B_SUB] && !$past(mode_oh[B_SUB])) |-> $past(mode_oh[B_WATCH]));

  assert_dt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dt_irq |=> !dt_irq);

  assert_dt_on_arrival_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dt_irq |-> (running && $past(halted)));

  assert_req_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sleep_req) |=> halted);

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_req (sleep_req),
  .mode_oh   (mode_oh),
  .clk_sel   (clk_sel),
  .dt_irq    (dt_irq)
);

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;

  localparam int M_FULL = 1, M_MED = 2, M_SUB = 4, M_SLP = 8, M_WCH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic       stby_sel = 1'b0, lowspd_sel = 1'b0, medspd_sel = 1'b0;
  logic       dt_en = 1'b0, tmr_lowclk = 1'b0;
  logic [2:0] wait_sel = 3'd0;
  logic       dt_irq_en = 1'b1, irq_mask = 1'b0, wake_irq = 1'b0;
  logic       lowclk_tick = 1'b1;
  logic [4:0] mode_oh;
  logic [1:0] clk_sel;
  logic       dt_irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  lpm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .stby_sel(stby_sel), .lowspd_sel(lowspd_sel), .medspd_sel(medspd_sel),
    .dt_en(dt_en), .tmr_lowclk(tmr_lowclk), .wait_sel(wait_sel),
    .dt_irq_en(dt_irq_en), .irq_mask(irq_mask), .wake_irq(wake_irq),
    .lowclk_tick(lowclk_tick), .mode_oh(mode_oh), .clk_sel(clk_sel),
    .dt_irq(dt_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int m, input int cs, input int irq);
    chk(req, "mode_oh", int'(mode_oh), m);
    chk(req, "clk_sel", int'(clk_sel), cs);
    chk(req, "dt_irq", int'(dt_irq), irq);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic s, input logic l, input logic m,
                         input logic d, input logic t);
    stby_sel = s; lowspd_sel = l; medspd_sel = m; dt_en = d; tmr_lowclk = t;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1", M_FULL, 0, 0);
  endtask

  task automatic t_full_to_med();
    set_cfg(0, 0, 1, 1, 0);
    pulse_sleep();
    chk_state("R3", M_SLP, 3, 0);
    @(negedge clk);
    chk_state("R3", M_MED, 1, 1);
    @(negedge clk);
    chk_state("R7", M_MED, 1, 0);
  endtask

  task automatic t_med_to_full();
    set_cfg(0, 0, 0, 1, 0);
    pulse_sleep();
    chk_state("R4", M_SLP, 3, 0);
    @(negedge clk);
    chk_state("R4", M_FULL, 0, 1);
    @(negedge clk);
    chk("R7", "dt_irq after pulse", int'(dt_irq), 0);
  endtask

  task automatic t_to_sub();
    set_cfg(1, 1, 0, 1, 1);
    pulse_sleep();
    chk_state("R5", M_WCH, 3, 0);
    @(negedge clk);
    chk_state("R5", M_SUB, 2, 1);
    @(negedge clk);
  endtask

  task automatic t_sub_to_full(input int sel);
    int k;
    set_cfg(1, 0, 0, 1, 1);
    wait_sel = 3'(sel);
    pulse_sleep();
    wait_sel = 3'd0;  // must not shorten the captured wait
    chk_state("R6", M_WCH, 3, 0);
    k = 0;
    for (int i = 1; i <= 2000; i++) begin
      @(negedge clk);
      k = i;
      if (mode_oh != 5'(M_WCH)) break;
    end
    chk("R6", "cycles in watch", k, 8 << sel);
    chk_state("R6", M_FULL, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_sub_gated();
    int k;
    set_cfg(1, 0, 0, 1, 1);
    wait_sel = 3'd0;
    pulse_sleep();
    lowclk_tick = 1'b0;
    k = 0;
    for (int i = 1; i <= 100; i++) begin
      lowclk_tick = ~lowclk_tick;
      @(negedge clk);
      k = i;
      if (mode_oh != 5'(M_WCH)) break;
    end
    lowclk_tick = 1'b1;
    chk("R6", "cycles with gated ticks", k, 15);
    chk_state("R6", M_FULL, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_dt_disabled();
    dt_irq_en = 1'b0;
    set_cfg(0, 0, 1, 1, 0);
    pulse_sleep();
    repeat (3) @(negedge clk);
    chk_state("R8", M_SLP, 3, 0);
    pulse_wake();
    chk_state("R8", M_FULL, 0, 0);
    dt_irq_en = 1'b1;
  endtask

  task automatic t_plain_active();
    set_cfg(0, 0, 0, 0, 0);
    pulse_sleep();
    chk_state("R10", M_SLP, 3, 0);
    irq_mask = 1'b1;
    pulse_wake();
    chk_state("R10", M_SLP, 3, 0);
    irq_mask = 1'b0;
    pulse_wake();
    chk_state("R10", M_FULL, 0, 0);
  endtask

  task automatic t_req_ignored();
    set_cfg(0, 0, 0, 0, 0);
    pulse_sleep();
    set_cfg(0, 0, 1, 1, 0);
    pulse_sleep();
    @(negedge clk);
    chk_state("R11", M_SLP, 3, 0);
    pulse_wake();
    chk_state("R11", M_FULL, 0, 0);
  endtask

  task automatic t_masked_lock();
    irq_mask = 1'b1;
    set_cfg(0, 0, 1, 1, 0);
    pulse_sleep();
    @(negedge clk);
    chk_state("R9", M_SLP, 3, 0);
    pulse_wake();
    chk_state("R9", M_SLP, 3, 0);
    irq_mask = 1'b0;
    pulse_wake();
    repeat (2) @(negedge clk);
    chk_state("R9", M_SLP, 3, 0);
    do_reset();
    chk_state("R9", M_FULL, 0, 0);
  endtask

  task automatic t_plain_sub();
    t_to_sub();
    set_cfg(0, 0, 0, 0, 0);
    pulse_sleep();
    repeat (20) @(negedge clk);
    chk_state("R10", M_WCH, 3, 0);
    pulse_wake();
    chk_state("R10", M_SUB, 2, 0);
  endtask

  initial begin
    #1_900_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_full_to_med();
    t_med_to_full();
    t_to_sub();
    t_sub_to_full(0);
    t_to_sub();
    t_sub_to_full(2);
    t_to_sub();
    t_sub_to_full(7);
    t_to_sub();
    t_sub_gated();
    t_dt_disabled();
    t_plain_active();
    t_req_ignored();
    t_masked_lock();
    t_plain_sub();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule